// File: doc/BRIEF.md
# Converter Result Packer for a Shared DMA Stream

This block sits between a set of two or three converters that run in lockstep and a single DMA request channel. Each converter hands over a result with a one-cycle strobe. The block keeps the results in small per-converter holding stores. It then forms 32-bit words in one of three packing styles and offers each word on a valid/ready handshake.

The 2-bit mode input chooses the packing style. 00 turns the block off. 01 sends one result per word. 10 sends two half-word results per word. 11 sends two byte results per word.

With three converters, the two pair styles step through a rotating order of converter pairs. Some pairs need a result from the following conversion round. In that case the earlier result stays in its holding store until its partner arrives, so no result is lost or repeated. Sometimes a converter delivers a result while its holding store is full and is not being drained in that cycle. That result is discarded, and a sticky overrun flag records the loss.

Top module: `conv_pack_dma`

## Requirements
- R1: After reset `word_valid` is 0 and `overrun` is 0.
- R2: With `mode_sel` = 00 the block is off. Strobes are ignored, no word is offered and `overrun` is not set. Entering this mode drops any pending word and all held results.
- R3: With `mode_sel` = 01 each word carries one result, zero-extended, in bits RES_W-1:0. With three converters the results are sent in converter order 1, 2, 3, repeating.
- R4: With `mode_sel` = 10 and three converters, each word carries two results. The pairs rotate in the order (2,1), (1,3), (3,2). The first result of a pair goes in bits 31:16 and the second in bits 15:0.
- R5: With `mode_sel` = 11 the pairing follows R4, but only the low byte of each result is packed. The first result's byte goes in bits 15:8, the second's in bits 7:0, and bits 31:16 are 0.
- R6: With two converters, mode 01 alternates converter 1 then 2, and modes 10 and 11 always pack the pair (2,1).
- R7: Every accepted result appears in exactly one word. A result that its pair needs from a later round is held until that partner arrives.
- R8: Once `word_valid` is high it stays high, and `word_data` stays unchanged, until `word_ready` is high. A word transfers on a cycle with both high.
- R9: When the output stage is free, a word is offered in the cycle after the clock edge that captures the last result it needs.
- R10: A result that arrives while its converter's store already holds DEPTH results, and that store is not drained in the same cycle, is discarded and sets `overrun`. The flag stays set until `overrun_clr` is high. A new discard in the same cycle as the clear wins.
- R11: A change between two non-off modes drops all held results and restarts the pair rotation at its first pair. A word already offered is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Packing mode: 00 off, 01 single, 10 half-word pair, 11 byte pair |
| conv_strobe | input | NUM_CONV | One result-valid strobe per converter |
| conv_result | input | NUM_CONV*RES_W | Converter results; converter n occupies slice n |
| overrun_clr | input | 1 | Clears the overrun flag |
| word_ready | input | 1 | DMA side accepts the offered word |
| word_valid | output | 1 | An output word is offered |
| word_data | output | 32 | Packed output word |
| overrun | output | 1 | Sticky flag: a result was discarded |

## Verification
Several properties are checked on every cycle. An offered word is held stable under backpressure. A word is loaded only into a free output stage. No holding store is popped while empty. A discard always raises the flag, and the flag stays set until cleared. The off mode and mode changes never load a word. Only the bench scenarios can show that the words contain the right results in the right rotating order for each mode and converter count. They also show that a held result is used exactly once across rounds, and that a discard under sustained backpressure leaves exactly the expected words in the stream.

// File: rtl/conv_pack_pkg.sv
package conv_pack_pkg;

  typedef enum logic [1:0] {
    PK_OFF       = 2'b00,
    PK_SINGLE    = 2'b01,
    PK_HALF_PAIR = 2'b10,
    PK_BYTE_PAIR = 2'b11
  } pack_mode_e;

  localparam int WORD_W = 32;
  localparam int SLOT_W = 16;

  // One result per word, zero-extended.
  function automatic logic [WORD_W-1:0] word_single(input logic [SLOT_W-1:0] r);
    return {16'h0000, r};
  endfunction

  // Two half-word results; the first-named result goes in the upper half.
  function automatic logic [WORD_W-1:0] word_half_pair(input logic [SLOT_W-1:0] hi,
                                                       input logic [SLOT_W-1:0] lo);
    return {hi, lo};
  endfunction

  // Two byte results in the low half-word; the upper half-word is zero.
  function automatic logic [WORD_W-1:0] word_byte_pair(input logic [SLOT_W-1:0] hi,
                                                       input logic [SLOT_W-1:0] lo);
    return {16'h0000, hi[7:0], lo[7:0]};
  endfunction

endpackage

// File: rtl/conv_hold_fifo.sv
module conv_hold_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          full, wr_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_ok = push && (!full || pop);
  assign drop  = push && full && !pop && !flush;
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (pop)   rd_ptr <= bump(rd_ptr);
      case ({wr_ok, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && wr_ok) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/pack_step_seq.sv
module pack_step_seq
  import conv_pack_pkg::*;
#(
  parameter int NUM_CONV = 3,
  parameter int IW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  input  pack_mode_e    mode,
  output logic [IW-1:0] hi_idx,
  output logic [IW-1:0] lo_idx,
  output logic          pair_mode
);
  logic [IW-1:0] step;
  logic [IW-1:0] last_step;

  assign pair_mode = (mode == PK_HALF_PAIR) || (mode == PK_BYTE_PAIR);

  always_comb begin
    if (!pair_mode)         last_step = IW'(NUM_CONV - 1);
    else if (NUM_CONV == 3) last_step = IW'(2);
    else                    last_step = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart)  step <= '0;
    else if (advance)       step <= (step == last_step) ? '0 : step + 1'b1;
  end

  // Rotation table: step -> (upper, lower) converter index, 0-based.
  always_comb begin
    hi_idx = step;
    lo_idx = step;
    if (pair_mode) begin
      if (NUM_CONV == 3) begin
        case (step)
          IW'(0):  begin hi_idx = IW'(1); lo_idx = IW'(0); end
          IW'(1):  begin hi_idx = IW'(0); lo_idx = IW'(2); end
          default: begin hi_idx = IW'(2); lo_idx = IW'(1); end
        endcase
      end else begin
        hi_idx = IW'(1);
        lo_idx = IW'(0);
      end
    end
  end

endmodule

// File: rtl/conv_pack_dma.sv
module conv_pack_dma
  import conv_pack_pkg::*;
#(
  parameter int NUM_CONV = 3,
  parameter int RES_W    = 12,
  parameter int DEPTH    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode_sel,
  input  logic [NUM_CONV-1:0]       conv_strobe,
  input  logic [NUM_CONV*RES_W-1:0] conv_result,
  input  logic                      overrun_clr,
  input  logic                      word_ready,
  output logic                      word_valid,
  output logic [WORD_W-1:0]         word_data,
  output logic                      overrun
);
  localparam int IW = $clog2(NUM_CONV);

  pack_mode_e          mode_e;
  logic [1:0]          mode_q;
  logic                mode_en, mode_chg, flush_all;
  logic [NUM_CONV-1:0] empty_vec, drop_vec, pop_vec, hi_oh, lo_oh;
  logic [RES_W-1:0]    res_head [NUM_CONV];
  logic [SLOT_W-1:0]   head16   [NUM_CONV];
  logic [IW-1:0]       hi_idx, lo_idx;
  logic                pair_mode, need_ok, out_free, load_evt, drop_any;
  logic [WORD_W-1:0]   new_word;

  assign mode_e    = pack_mode_e'(mode_sel);
  assign mode_en   = (mode_e != PK_OFF);
  assign mode_chg  = (mode_sel != mode_q);
  assign flush_all = !mode_en || mode_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 2'b00;
    else        mode_q <= mode_sel;
  end

  for (genvar i = 0; i < NUM_CONV; i++) begin : g_store
    conv_hold_fifo #(.W(RES_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_all),
      .push  (conv_strobe[i] && !flush_all),
      .pop   (pop_vec[i]),
      .din   (conv_result[i*RES_W +: RES_W]),
      .dout  (res_head[i]),
      .empty (empty_vec[i]),
      .drop  (drop_vec[i])
    );
    assign head16[i] = SLOT_W'(res_head[i]);
  end

  pack_step_seq #(.NUM_CONV(NUM_CONV), .IW(IW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (flush_all),
    .advance   (load_evt),
    .mode      (mode_e),
    .hi_idx    (hi_idx),
    .lo_idx    (lo_idx),
    .pair_mode (pair_mode)
  );

  assign need_ok  = pair_mode ? (!empty_vec[hi_idx] && !empty_vec[lo_idx])
                              : !empty_vec[lo_idx];
  assign out_free = !word_valid || word_ready;
  assign load_evt = !flush_all && need_ok && out_free;
  assign hi_oh    = NUM_CONV'(1) << hi_idx;
  assign lo_oh    = NUM_CONV'(1) << lo_idx;
  assign pop_vec  = load_evt ? (lo_oh | (pair_mode ? hi_oh : '0)) : '0;
  assign drop_any = |drop_vec;

  always_comb begin
    case (mode_e)
      PK_SINGLE:    new_word = word_single(head16[lo_idx]);
      PK_HALF_PAIR: new_word = word_half_pair(head16[hi_idx], head16[lo_idx]);
      PK_BYTE_PAIR: new_word = word_byte_pair(head16[hi_idx], head16[lo_idx]);
      default:      new_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
    end else if (!mode_en) begin
      word_valid <= 1'b0;
    end else if (load_evt) begin
      word_valid <= 1'b1;
      word_data  <= new_word;
    end else if (word_ready) begin
      word_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           overrun <= 1'b0;
    else if (drop_any)    overrun <= 1'b1;
    else if (overrun_clr) overrun <= 1'b0;
  end

endmodule

// File: rtl/conv_pack_dma_chk.sv
module conv_pack_dma_chk #(
  parameter int NUM_CONV = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode_sel,
  input logic                word_valid,
  input logic                word_ready,
  input logic [31:0]         word_data,
  input logic                overrun,
  input logic                overrun_clr,
  input logic                load_evt,
  input logic                drop_any,
  input logic                flush_all,
  input logic [NUM_CONV-1:0] pop_vec,
  input logic [NUM_CONV-1:0] empty_vec
);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && mode_sel != 2'b00) |=> (word_valid && $stable(word_data)));

  p_load_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (!word_valid || word_ready));

  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_vec & empty_vec) == '0);

  p_drop_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_any |=> overrun);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !overrun_clr) |=> overrun);

  p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> !word_valid);

  p_flush_no_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> !load_evt);

  p_offer_after_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(load_evt));

endmodule

bind conv_pack_dma conv_pack_dma_chk #(.NUM_CONV(NUM_CONV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_sel    (mode_sel),
  .word_valid  (word_valid),
  .word_ready  (word_ready),
  .word_data   (word_data),
  .overrun     (overrun),
  .overrun_clr (overrun_clr),
  .load_evt    (load_evt),
  .drop_any    (drop_any),
  .flush_all   (flush_all),
  .pop_vec     (pop_vec),
  .empty_vec   (empty_vec)
);

// File: tb/conv_pack_dma_bench.sv
module conv_pack_dma_bench;

  localparam logic [11:0] STIM [18] = '{
    12'h1A3, 12'h2B4, 12'h3C5, 12'h4D6, 12'h5E7, 12'h6F8,
    12'h719, 12'h82A, 12'h93B, 12'hA4C, 12'hB5D, 12'hC6E,
    12'hD7F, 12'hE81, 12'hF92, 12'h0A3, 12'h1B4, 12'h2C5
  };
  localparam logic [1:0] MODES [3] = '{2'b01, 2'b10, 2'b11};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [2:0]  strobe = '0;
  logic [35:0] result = '0;
  logic        clr = 1'b0;
  logic        ready = 1'b1;
  logic        word_valid, overrun;
  logic [31:0] word_data;

  logic [1:0]  d_mode = 2'b00;
  logic [1:0]  d_strobe = '0;
  logic [23:0] d_result = '0;
  logic        d_valid, d_ovr;
  logic [31:0] d_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] cap [64];
  int cap_n = 0;
  logic [31:0] dcap [64];
  int dcap_n = 0;

  always #10 clk = ~clk;

  conv_pack_dma #(.NUM_CONV(3), .RES_W(12), .DEPTH(2)) u_conv_pack_dma (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .conv_strobe(strobe),
    .conv_result(result), .overrun_clr(clr), .word_ready(ready),
    .word_valid(word_valid), .word_data(word_data), .overrun(overrun));

  conv_pack_dma #(.NUM_CONV(2), .RES_W(12), .DEPTH(2)) u_conv_pack_dma_dual (
    .clk(clk), .rst_n(rst_n), .mode_sel(d_mode), .conv_strobe(d_strobe),
    .conv_result(d_result), .overrun_clr(1'b0), .word_ready(1'b1),
    .word_valid(d_valid), .word_data(d_data), .overrun(d_ovr));

  always @(negedge clk) begin
    if (word_valid && ready && cap_n < 64) begin cap[cap_n] = word_data; cap_n++; end
    if (d_valid && dcap_n < 64) begin dcap[dcap_n] = d_data; dcap_n++; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic send(input logic [11:0] a, input logic [11:0] b, input logic [11:0] c);
    strobe = 3'b111; result = {c, b, a};
    step();
    strobe = '0;
  endtask

  task automatic d_send(input logic [11:0] a, input logic [11:0] b);
    d_strobe = 2'b11; d_result = {b, a};
    step();
    d_strobe = '0;
  endtask

  // Flattened stream: single mode takes element k, pair modes take (2k+1, 2k).
  function automatic logic [31:0] exp_word(input logic [1:0] m, input int k);
    case (m)
      2'b01:   return {20'h0, STIM[k]};
      2'b10:   return {4'h0, STIM[2*k+1], 4'h0, STIM[2*k]};
      default: return {16'h0, STIM[2*k+1][7:0], STIM[2*k][7:0]};
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    @(negedge clk);
    check("R1 valid in reset", {31'h0, word_valid}, 32'h0);
    check("R1 overrun in reset", {31'h0, overrun}, 32'h0);
    rst_n = 1'b1;
    step(2);
    @(negedge clk);
    check("R1 valid after reset", {31'h0, word_valid}, 32'h0);

    // Table walk over the three packing modes
    for (int mi = 0; mi < 3; mi++) begin
      logic [1:0] m;
      int n_exp;
      m = MODES[mi];
      mode_sel = 2'b00; step(2);
      mode_sel = m;     step(2);
      cap_n = 0;
      for (int r = 0; r < 6; r++) begin
        send(STIM[3*r], STIM[3*r+1], STIM[3*r+2]);
        step(3);
      end
      step(8);
      n_exp = (m == 2'b01) ? 18 : 9;
      check("R7 word count", 32'(cap_n), 32'(n_exp));
      for (int k = 0; k < n_exp; k++)
        check((m == 2'b01) ? "R3 single order" : (m == 2'b10) ? "R4 half pair rotation"
              : "R5 byte pair rotation", cap[k], exp_word(m, k));
    end

    // R9 latency
    mode_sel = 2'b00; step(2); mode_sel = 2'b01; step(2);
    send(12'h111, 12'h222, 12'h333);
    @(negedge clk);
    check("R9 not yet offered", {31'h0, word_valid}, 32'h0);
    step();
    @(negedge clk);
    check("R9 offered next cycle", {31'h0, word_valid}, 32'h1);
    check("R9 first word", word_data, 32'h111);
    step(6);

    // R10 / R8 / R7 overrun under backpressure
    mode_sel = 2'b00; step(2); mode_sel = 2'b01; step(2);
    ready = 1'b0;
    send(12'h101, 12'h102, 12'h103);
    send(12'h201, 12'h202, 12'h203);
    send(12'h301, 12'h302, 12'h303);
    @(negedge clk);
    check("R10 overrun set", {31'h0, overrun}, 32'h1);
    check("R8 valid held", {31'h0, word_valid}, 32'h1);
    step(4);
    @(negedge clk);
    check("R8 data stable under stall", word_data, 32'h101);
    cap_n = 0;
    ready = 1'b1;
    step(12);
    check("R10 surviving word count", 32'(cap_n), 32'd7);
    check("R7 word 1", cap[1], 32'h102);
    check("R7 word 3", cap[3], 32'h201);
    check("R10 last survivor", cap[6], 32'h301);
    check("R10 sticky", {31'h0, overrun}, 32'h1);
    clr = 1'b1; step(); clr = 1'b0;
    @(negedge clk);
    check("R10 cleared", {31'h0, overrun}, 32'h0);

    // R2 off mode ignores strobes
    mode_sel = 2'b00; step(2);
    cap_n = 0;
    for (int r = 0; r < 4; r++) send(12'h0AA, 12'h0BB, 12'h0CC);
    step(5);
    check("R2 no words when off", 32'(cap_n), 32'd0);
    check("R2 no overrun when off", {31'h0, overrun}, 32'h0);

    // R11 mode change keeps pending word, drops held results
    mode_sel = 2'b01; step(2);
    ready = 1'b0;
    send(12'h511, 12'h522, 12'h533);
    step(2);
    mode_sel = 2'b10; step();
    @(negedge clk);
    check("R11 pending kept valid", {31'h0, word_valid}, 32'h1);
    check("R11 pending kept data", word_data, 32'h511);
    cap_n = 0;
    ready = 1'b1;
    step(4);
    check("R11 held results dropped", 32'(cap_n), 32'd1);
    send(12'h611, 12'h622, 12'h633);
    step(4);
    check("R11 rotation restarted", 32'(cap_n), 32'd2);
    check("R11 first pair", cap[1], 32'h06220611);

    // R6 two converters
    d_mode = 2'b10; step(2);
    dcap_n = 0;
    d_send(12'h711, 12'h722); step(2);
    d_send(12'h811, 12'h822); step(2);
    d_send(12'h911, 12'h922); step(4);
    check("R6 dual pair count", 32'(dcap_n), 32'd3);
    check("R6 dual pair 0", dcap[0], 32'h07220711);
    check("R6 dual pair 2", dcap[2], 32'h09220911);
    d_mode = 2'b11; step(2);
    dcap_n = 0;
    d_send(12'hA12, 12'hB34); step(4);
    check("R6 dual byte pair", dcap[0], 32'h00003412);
    d_mode = 2'b01; step(2);
    dcap_n = 0;
    d_send(12'hC11, 12'hC22); step(3);
    d_send(12'hD11, 12'hD22); step(4);
    check("R6 dual single count", 32'(dcap_n), 32'd4);
    check("R6 dual single 1", dcap[1], 32'h00000C22);
    check("R6 dual single 2", dcap[2], 32'h00000D11);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule